// File: doc/BRIEF.md
# CAN Controller Configuration Guard and Time-Quantum Prescaler

This block sits in front of the register file of a CAN controller. It guards the settings that must not change while the controller is on the bus, and it generates the time-quantum tick. Software reaches it through a plain synchronous register port. Each access takes one cycle. There is no back-pressure: the port is always ready, so a write is taken on the edge where `reg_wr` is high, and `reg_rdata` always shows the register selected by `reg_addr`. No streaming data passes through the block, so it has no valid/ready interface.

Software requests initialization mode by setting a request bit. The block answers with an acknowledge bit a fixed two cycles later. While the acknowledge bit is high, the configuration registers accept writes. The configuration registers are the second control register, two timing registers, the filter control register, eight acceptance codes and eight acceptance masks. While the controller is on-line, writes to them are dropped. The receive and transmit error counters are loaded only from the bit engine; software can read them but cannot write them. The module-enable bit can be written once after reset.

The transmit pin is held recessive from the moment initialization is requested, and also during power-down. The tick is generated by dividing a clock-enable by 1 to 64. A select bit in a protected register picks which clock-enable is divided.

Top module: `can_cfg_guard`

## Requirements
- R1: Reset state: request bit is 1, acknowledge bit is 1, enable bit is 0 and not yet written, both error counters read 0, every configuration register reads 0, `can_tx` is 1.
- R2: `init_ack` equals the value the request bit (CTRL0 bit 0, address 0x00) held two clock edges earlier, for both rising and falling changes. The acknowledge is readable as CTRL1 bit 0 (address 0x01), and writes to that bit have no effect.
- R3: A write to a configuration register takes effect only if `init_ack` is 1 before the edge; otherwise it is ignored. The configuration registers are: CTRL1 bits 7:1 at 0x01, TIMING0 at 0x02, TIMING1 at 0x03, FILTER_CTRL at 0x04, acceptance codes at 0x08–0x0F and acceptance masks at 0x10–0x17.
- R4: The error counters at 0x05 (receive) and 0x06 (transmit) ignore register writes. When `err_load` is high at an edge, they take `rx_err_in` and `tx_err_in`.
- R5: The first write to CTRL0 after reset stores bit 7 as the enable bit (`module_en`). Bit 7 of every later CTRL0 write is discarded, while bit 0 (request) is always updated. CTRL0 reads as {enable, 6'b0, request}.
- R6: `can_tx` is 1 in the same cycle whenever the request bit, `init_ack` or `power_down` is 1; otherwise `can_tx` equals `engine_tx`.
- R7: `clk_sel` equals CTRL1 bit 6. When it is 1, the prescaler counts `bus_ce`; when it is 0, the prescaler counts `osc_ce`.
- R8: With n = TIMING0 bits 5:0, `tq_tick` is a one-cycle pulse on every (n+1)-th selected enable. `tq_tick` is never high while `init_ack` is 1. The count restarts from zero when initialization is left.
- R9: Reads are allowed in every mode. Addresses 0x07 and 0x18–0x1F read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the register at `reg_addr` |
| osc_ce | input | 1 | Oscillator-derived clock enable |
| bus_ce | input | 1 | Bus-clock-derived clock enable |
| power_down | input | 1 | Controller is in power-down |
| engine_tx | input | 1 | Transmit bit from the bit engine |
| err_load | input | 1 | Load strobe for the error counters |
| rx_err_in | input | 8 | New receive error count |
| tx_err_in | input | 8 | New transmit error count |
| can_tx | output | 1 | Transmit pin, recessive high |
| clk_sel | output | 1 | Selected clock source, 1 = bus clock |
| tq_tick | output | 1 | Time-quantum tick pulse |
| module_en | output | 1 | Enable bit |
| init_ack | output | 1 | Initialization acknowledge |

## Verification
A lock that opens at the wrong moment corrupts a stored configuration value. That error shows in `reg_rdata` as soon as the register is read back, and it changes the `tq_tick` spacing within one prescaler period. A handshake pipeline that is out by one stage moves the `init_ack` edge by a cycle, and the cycle-by-cycle comparison catches that at once. A prescaler count that is off moves the next tick by at least one selected enable. Running every phase with random enables, power-down and bit-engine activity checks that `can_tx` is recessive in every cycle where it must be.

// File: rtl/can_cfg_pkg.sv
package can_cfg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL0 = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 5'h01;
  localparam logic [ADDR_W-1:0] A_TIME0 = 5'h02;
  localparam logic [ADDR_W-1:0] A_TIME1 = 5'h03;
  localparam logic [ADDR_W-1:0] A_FCTRL = 5'h04;
  localparam logic [ADDR_W-1:0] A_RXERR = 5'h05;
  localparam logic [ADDR_W-1:0] A_TXERR = 5'h06;
  localparam int CODE_BASE = 8;
  localparam int MASK_BASE = 16;

  localparam int EN_BIT   = 7;
  localparam int REQ_BIT  = 0;
  localparam int CSEL_BIT = 6;

  typedef struct packed {
    logic             req;
    logic             en;
    logic             en_used;
  } ctrl0_t;
endpackage

// File: rtl/can_init_sync.sv
module can_init_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  output logic init_ack
);
  logic [SYNC_STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= init_req;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign init_ack = chain_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      // R2: acknowledge trails the request by exactly two edges
      p_ack_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_ack == $past(init_req, 2));
    end
  endgenerate
endmodule

// File: rtl/can_cfg_regs.sv
module can_cfg_regs
  import can_cfg_pkg::*;
#(
  parameter int NUM_FILT = 8,
  parameter int PRESC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              init_ack,
  input  logic              err_load,
  input  logic [DATA_W-1:0] rx_err_in,
  input  logic [DATA_W-1:0] tx_err_in,
  output logic              init_req,
  output logic              module_en,
  output logic              clk_src,
  output logic [PRESC_W-1:0] presc
);
  ctrl0_t            c0_q;
  logic [DATA_W-1:1] ctrl1_q;
  logic [DATA_W-1:0] time0_q, time1_q, fctrl_q, rxerr_q, txerr_q;
  logic [DATA_W-1:0] code_q [NUM_FILT];
  logic [DATA_W-1:0] mask_q [NUM_FILT];

  logic cfg_we;
  assign cfg_we = reg_wr && init_ack;

  // control register 0: request always writable, enable written once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= '{req: 1'b1, en: 1'b0, en_used: 1'b0};
    end else if (reg_wr && reg_addr == A_CTRL0) begin
      c0_q.req <= reg_wdata[REQ_BIT];
      if (!c0_q.en_used) begin
        c0_q.en      <= reg_wdata[EN_BIT];
        c0_q.en_used <= 1'b1;
      end
    end
  end

  // protected configuration set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1_q <= '0;
      time0_q <= '0;
      time1_q <= '0;
      fctrl_q <= '0;
      for (int i = 0; i < NUM_FILT; i++) begin
        code_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (cfg_we) begin
      case (reg_addr)
        A_CTRL1: ctrl1_q <= reg_wdata[DATA_W-1:1];
        A_TIME0: time0_q <= reg_wdata;
        A_TIME1: time1_q <= reg_wdata;
        A_FCTRL: fctrl_q <= reg_wdata;
        default: ;
      endcase
      for (int i = 0; i < NUM_FILT; i++) begin
        if (reg_addr == ADDR_W'(CODE_BASE + i)) code_q[i] <= reg_wdata;
        if (reg_addr == ADDR_W'(MASK_BASE + i)) mask_q[i] <= reg_wdata;
      end
    end
  end

  // error counters: only the bit engine updates them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxerr_q <= '0;
      txerr_q <= '0;
    end else if (err_load) begin
      rxerr_q <= rx_err_in;
      txerr_q <= tx_err_in;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL0: begin
        reg_rdata[EN_BIT]  = c0_q.en;
        reg_rdata[REQ_BIT] = c0_q.req;
      end
      A_CTRL1: reg_rdata = {ctrl1_q, init_ack};
      A_TIME0: reg_rdata = time0_q;
      A_TIME1: reg_rdata = time1_q;
      A_FCTRL: reg_rdata = fctrl_q;
      A_RXERR: reg_rdata = rxerr_q;
      A_TXERR: reg_rdata = txerr_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_FILT; i++) begin
      if (reg_addr == ADDR_W'(CODE_BASE + i)) reg_rdata = code_q[i];
      if (reg_addr == ADDR_W'(MASK_BASE + i)) reg_rdata = mask_q[i];
    end
  end

  assign init_req  = c0_q.req;
  assign module_en = c0_q.en;
  assign clk_src   = ctrl1_q[CSEL_BIT];
  assign presc     = time0_q[PRESC_W-1:0];

  // R3: timing register frozen while on-line
  p_locked_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !init_ack && reg_addr == A_TIME0) |=> $stable(time0_q));
  // R3: clock-source select frozen while on-line
  p_locked_csel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_ack) |=> $stable(clk_src));
  // R4: software writes never reach the error counters
  p_err_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !err_load && (reg_addr == A_RXERR || reg_addr == A_TXERR))
      |=> ($stable(rxerr_q) && $stable(txerr_q)));
  // R5: enable bit never changes after its first write
  p_en_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c0_q.en_used |=> $stable(module_en));
endmodule

// File: rtl/can_tq_prescaler.sv
module can_tq_prescaler #(
  parameter int PRESC_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_ce,
  input  logic               bus_ce,
  input  logic               use_bus,
  input  logic               hold,
  input  logic [PRESC_W-1:0] div_m1,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q;
  logic               ce;
  logic               at_end;

  assign ce     = use_bus ? bus_ce : osc_ce;
  assign at_end = (cnt_q == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (hold)   cnt_q <= '0;
    else if (ce)     cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  assign tick = !hold && ce && at_end;

  // R8: no tick while initialization is acknowledged
  p_no_tick_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !tick);
  // R8: counter is at zero on the first cycle after leaving init
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (cnt_q == '0));
  // R7: tick only on an enable of the selected source
  p_tick_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (use_bus ? bus_ce : osc_ce));
endmodule

// File: rtl/can_cfg_guard.sv
module can_cfg_guard
  import can_cfg_pkg::*;
#(
  parameter int NUM_FILT    = 8,
  parameter int PRESC_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              osc_ce,
  input  logic              bus_ce,
  input  logic              power_down,
  input  logic              engine_tx,
  input  logic              err_load,
  input  logic [DATA_W-1:0] rx_err_in,
  input  logic [DATA_W-1:0] tx_err_in,
  output logic              can_tx,
  output logic              clk_sel,
  output logic              tq_tick,
  output logic              module_en,
  output logic              init_ack
);
  logic              req_w;
  logic [PRESC_W-1:0] presc_w;

  can_init_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (req_w),
    .init_ack (init_ack)
  );

  can_cfg_regs #(.NUM_FILT(NUM_FILT), .PRESC_W(PRESC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .init_ack  (init_ack),
    .err_load  (err_load),
    .rx_err_in (rx_err_in),
    .tx_err_in (tx_err_in),
    .init_req  (req_w),
    .module_en (module_en),
    .clk_src   (clk_sel),
    .presc     (presc_w)
  );

  can_tq_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_ce  (osc_ce),
    .bus_ce  (bus_ce),
    .use_bus (clk_sel),
    .hold    (init_ack),
    .div_m1  (presc_w),
    .tick    (tq_tick)
  );

  // recessive as soon as init is requested, through the whole handshake
  assign can_tx = (req_w || init_ack || power_down) ? 1'b1 : engine_tx;

  // R6: pin recessive whenever offline
  p_tx_recessive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_w || init_ack || power_down) |-> can_tx);
endmodule

// File: tb/tb_can_cfg_guard.sv
`timescale 1ns/1ps
module tb_can_cfg_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       osc_ce = 1'b0, bus_ce = 1'b0, power_down = 1'b0, engine_tx = 1'b1;
  logic       err_load = 1'b0;
  logic [7:0] rx_err_in = '0, tx_err_in = '0;
  logic       can_tx, clk_sel, tq_tick, module_en, init_ack;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_cfg_guard dut (.*);

  // behavioural reference
  logic       m_req, m_s1, m_ack, m_en, m_enw;
  logic [7:0] m_c1, m_t0, m_t1, m_fc, m_rx, m_tx;
  logic [7:0] m_code [8];
  logic [7:0] m_mask [8];
  logic [5:0] m_cnt;

  always @(posedge clk or negedge rst_n) begin
    logic old_ack, old_req, ce;
    if (!rst_n) begin
      m_req = 1; m_s1 = 1; m_ack = 1; m_en = 0; m_enw = 0;
      m_c1 = 0; m_t0 = 0; m_t1 = 0; m_fc = 0; m_rx = 0; m_tx = 0; m_cnt = 0;
      for (int i = 0; i < 8; i++) begin m_code[i] = 0; m_mask[i] = 0; end
    end else begin
      old_ack = m_ack; old_req = m_req;
      ce = m_c1[6] ? bus_ce : osc_ce;
      if (old_ack) m_cnt = 0;
      else if (ce) m_cnt = (m_cnt == m_t0[5:0]) ? 6'd0 : m_cnt + 6'd1;
      m_ack = m_s1; m_s1 = old_req;
      if (err_load) begin m_rx = rx_err_in; m_tx = tx_err_in; end
      if (reg_wr) begin
        if (reg_addr == 0) begin
          m_req = reg_wdata[0];
          if (!m_enw) begin m_en = reg_wdata[7]; m_enw = 1; end
        end else if (old_ack) begin
          if (reg_addr == 1) m_c1 = reg_wdata & 8'hFE;
          if (reg_addr == 2) m_t0 = reg_wdata;
          if (reg_addr == 3) m_t1 = reg_wdata;
          if (reg_addr == 4) m_fc = reg_wdata;
          if (reg_addr >= 8 && reg_addr < 16) m_code[reg_addr-8] = reg_wdata;
          if (reg_addr >= 16 && reg_addr < 24) m_mask[reg_addr-16] = reg_wdata;
        end
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [4:0] a);
    if (a == 0) return {m_en, 6'd0, m_req};
    if (a == 1) return m_c1 | {7'd0, m_ack};
    if (a == 2) return m_t0;
    if (a == 3) return m_t1;
    if (a == 4) return m_fc;
    if (a == 5) return m_rx;
    if (a == 6) return m_tx;
    if (a >= 8 && a < 16) return m_code[a-8];
    if (a >= 16 && a < 24) return m_mask[a-16];
    return 8'h00;
  endfunction

  function automatic string rd_tag(logic [4:0] a);
    if (a == 0) return "R5";
    if (a == 1) return "R2 R3";
    if (a == 5 || a == 6) return "R4";
    if (a == 7 || a >= 24) return "R9";
    return "R3";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic ce;
      ce = m_c1[6] ? bus_ce : osc_ce;
      check(rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
      check("R2", {7'd0, init_ack}, {7'd0, m_ack});
      check("R5", {7'd0, module_en}, {7'd0, m_en});
      check("R6", {7'd0, can_tx},
            {7'd0, (m_req || m_ack || power_down) ? 1'b1 : engine_tx});
      check("R7", {7'd0, clk_sel}, {7'd0, m_c1[6]});
      check("R8", {7'd0, tq_tick}, {7'd0, !m_ack && ce && (m_cnt == m_t0[5:0])});
    end
  end

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      reg_addr  = 5'($urandom % 32);
      reg_wdata = 8'($urandom);
      reg_wr    = (($urandom % 6) == 0) && (reg_addr != 0);
      osc_ce    = 1'($urandom % 2);
      bus_ce    = ($urandom % 3) != 0;
      engine_tx = 1'($urandom % 2);
      power_down = ($urandom % 16) == 0;
      err_load  = ($urandom % 8) == 0;
      rx_err_in = 8'($urandom);
      tx_err_in = 8'($urandom);
    end
    reg_wr = 0; err_load = 0; power_down = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state seen at the ports
    reg_addr = 5'h05;
    @(negedge clk);
    check("R1", reg_rdata, 8'h00);
    check("R1", {7'd0, can_tx}, 8'h01);
    check("R1", {7'd0, module_en}, 8'h00);
    check("R1", {7'd0, init_ack}, 8'h01);
    // configure while in init
    wr(5'h02, 8'h02);
    wr(5'h01, 8'h41);
    wr(5'h03, 8'h5A);
    wr(5'h04, 8'h33);
    for (int i = 0; i < 8; i++) begin
      wr(5'(8 + i), 8'(8'h10 + i));
      wr(5'(16 + i), 8'(8'hE0 - i));
    end
    wr(5'h05, 8'hAA);   // R4: must be dropped
    wr(5'h06, 8'h55);
    wr(5'h00, 8'h81);   // R5: first write sets enable
    wr(5'h00, 8'h00);   // leave init, enable kept
    idle(300);
    wr(5'h00, 8'h01);   // re-enter init
    idle(4);
    wr(5'h02, 8'h00);   // divide by 1
    wr(5'h01, 8'h00);   // oscillator source
    wr(5'h00, 8'h00);
    idle(300);
    wr(5'h00, 8'h81);
    idle(4);
    wr(5'h02, 8'h3F);   // divide by 64
    wr(5'h01, 8'h40);
    wr(5'h00, 8'h80);
    idle(800);
    for (int a = 0; a < 32; a++) begin
      @(posedge clk); #1 reg_addr = 5'(a);
    end
    @(posedge clk); #1;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule